// File: doc/BRIEF.md
# Serial Peripheral Global Control

This block is the shared control logic of a serial-communications peripheral that contains a queued SPI engine and two UART-style channels. A 16-bit register bus with per-byte lane enables and a supervisor/user flag reaches a small set of global registers and the SPI queue RAM. The configuration register holds a stop bit and a freeze-enable bit. The stop bit gates the peripheral clock enable. While the stop bit is set, only the configuration register gives valid read data, but every write still takes effect.

The block also produces halt requests for the SPI engine and for the first UART channel's transmit queue. A debug freeze input halts the UART transmit queue in every case. It halts the SPI engine only when freeze-enable is set. Software can also halt the SPI through a request bit and then poll an acknowledge flag before it sets stop. Every halt takes effect on a transfer-boundary pulse from the engine it applies to. A 32-bit access is issued on this bus as two half-word cycles to consecutive register addresses.

Each access is accepted in the cycle where `busValid` is high. Its response (`respValid`, `busRdata`, `rdInvalid`, `busErr`) appears in the next cycle and lasts one cycle. Register addresses are half-word indices:
- 0: configuration. Bit 15 is stop and bit 14 is freeze-enable. Supervisor only.
- 1: interrupt levels, 16 bits. Supervisor only.
- 2: SPI control. Bit 0 is the halt request.
- 3: SPI status, read-only. Bit 0 is the halt acknowledge.
- Any address with its top bit set is the queue RAM, indexed by the lower bits.

Other addresses read as zero and ignore writes.

Top module: `serial_periph_global_ctl`

## Requirements
- R1: After reset the stop bit, the freeze-enable bit, the halt request and all registers read zero. `periphClkEn` is 1, and `spiHalt` and `uartTxHalt` are 0.
- R2: `periphClkEn` is 0 from the cycle after a write that sets configuration bit 15, and returns to 1 the cycle after a write that clears it.
- R3: While stop is set, a read of the configuration register returns its value with `rdInvalid`=0. A read of any other register or of the queue RAM returns 0 with `rdInvalid`=1.
- R4: While stop is set, writes to the interrupt-level register and to the queue RAM are stored. They read back once stop is cleared.
- R5: `busBe[1]` enables data bits 15:8 and `busBe[0]` enables bits 7:0. Disabled lanes keep their old contents.
- R6: A user-mode access (`busSuper`=0) to address 0 or 1 raises `busErr` for exactly the response cycle. Such a write is discarded and such a read returns 0.
- R7: User-mode accesses to the SPI control register and the queue RAM complete normally with `busErr`=0.
- R8: With freeze-enable set and `freezeIn` high, `spiHalt` stays 0 until an `spiBoundary` pulse arrives. It is 1 from the cycle after that pulse, and drops the cycle after `freezeIn` falls.
- R9: With freeze-enable clear, `freezeIn` leaves `spiHalt` at 0. `uartTxHalt` still rises the cycle after the first `uartBoundary` pulse while `freezeIn` is high, and drops the cycle after `freezeIn` falls.
- R10: With the halt request (SPI control bit 0) set, status bit 0 and `spiHalt` become 1 the cycle after an `spiBoundary` pulse. Both clear one cycle after the request is written back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Half-word address |
| busBe | input | DATA_W/8 | Byte lane enables |
| busWdata | input | DATA_W | Write data |
| busSuper | input | 1 | 1 = supervisor access |
| freezeIn | input | 1 | Debug freeze request |
| spiBoundary | input | 1 | SPI transfer-boundary pulse |
| uartBoundary | input | 1 | UART transmit boundary pulse |
| busRdata | output | DATA_W | Read data, response cycle |
| respValid | output | 1 | Response cycle marker |
| busErr | output | 1 | Privilege violation, response cycle |
| rdInvalid | output | 1 | Read blocked by stop mode |
| periphClkEn | output | 1 | Peripheral clock enable |
| spiHalt | output | 1 | Halt to the SPI engine |
| uartTxHalt | output | 1 | Halt to the UART transmit queue |

## Verification
A corrupted stop bit shows on `periphClkEn` one cycle after the write that went wrong. It also shows as a wrong `rdInvalid` on the very next read. A wrong halt state shows on `spiHalt` or `uartTxHalt` one cycle after a boundary pulse or a freeze edge. A lost or misdirected write stays hidden until it is read back, and in stop mode it can only be seen after stop is cleared. The directed tests therefore read back every write they depend on.

// File: rtl/spgc_pkg.sv
package spgc_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_CFG, SEL_LVL, SEL_SPICTL, SEL_SPISTAT, SEL_RAM
  } rdSel_e;

  typedef struct packed {
    logic   wrCfg;
    logic   wrLvl;
    logic   wrSpiCtl;
    logic   wrRam;
    logic   rdLoad;
    rdSel_e rdSel;
  } strobes_t;

  localparam int CFG_STOP_BIT = 15;
  localparam int CFG_FRZ_BIT  = 14;
  localparam int SPI_HALT_BIT = 0;
endpackage

// File: rtl/spgc_ctrl.sv
module spgc_ctrl
  import spgc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busSuper,
  input  logic              stopBit,
  input  logic              frzEn,
  input  logic              haltReqBit,
  input  logic              freezeIn,
  input  logic              spiBoundary,
  input  logic              uartBoundary,
  output strobes_t          strb,
  output logic              respValid,
  output logic              busErr,
  output logic              rdInvalid,
  output logic              spiHalt,
  output logic              uartTxHalt
);
  logic isRam, lowZero, isCfg, isLvl, isCtl, isStat;
  logic denied, granted, blocked, spiReq;
  logic spiHaltQ, uartHaltQ;

  assign isRam   = busAddr[ADDR_W-1];
  assign lowZero = (busAddr[ADDR_W-2:2] == '0);
  assign isCfg   = !isRam && lowZero && busAddr[1:0] == 2'd0;
  assign isLvl   = !isRam && lowZero && busAddr[1:0] == 2'd1;
  assign isCtl   = !isRam && lowZero && busAddr[1:0] == 2'd2;
  assign isStat  = !isRam && lowZero && busAddr[1:0] == 2'd3;

  assign denied  = busValid && !busSuper && (isCfg || isLvl);
  assign granted = busValid && !denied;
  assign blocked = stopBit && !isCfg;

  always_comb begin
    strb          = '0;
    strb.rdSel    = SEL_NONE;
    strb.wrCfg    = granted && busWrite && isCfg;
    strb.wrLvl    = granted && busWrite && isLvl;
    strb.wrSpiCtl = granted && busWrite && isCtl;
    strb.wrRam    = granted && busWrite && isRam;
    strb.rdLoad   = granted && !busWrite && !blocked;
    if      (isCfg)  strb.rdSel = SEL_CFG;
    else if (isLvl)  strb.rdSel = SEL_LVL;
    else if (isCtl)  strb.rdSel = SEL_SPICTL;
    else if (isStat) strb.rdSel = SEL_SPISTAT;
    else if (isRam)  strb.rdSel = SEL_RAM;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      busErr    <= 1'b0;
      rdInvalid <= 1'b0;
    end else begin
      respValid <= busValid;
      busErr    <= denied;
      rdInvalid <= granted && !busWrite && blocked;
    end
  end

  assign spiReq = haltReqBit || (frzEn && freezeIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spiHaltQ  <= 1'b0;
      uartHaltQ <= 1'b0;
    end else begin
      spiHaltQ  <= spiReq && (spiHaltQ || spiBoundary);
      uartHaltQ <= freezeIn && (uartHaltQ || uartBoundary);
    end
  end

  assign spiHalt    = spiHaltQ;
  assign uartTxHalt = uartHaltQ;

  assert_user_denied_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busSuper && !busAddr[ADDR_W-1] && busAddr[ADDR_W-2:1] == '0) |=> busErr);
  assert_spi_halt_boundary_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiHalt) |-> $past(spiBoundary));
  assert_uart_halt_boundary_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uartTxHalt) |-> $past(freezeIn && uartBoundary));
  assert_halt_needs_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    spiHalt |-> $past(haltReqBit || (frzEn && freezeIn)));
endmodule

// File: rtl/spgc_regs.sv
module spgc_regs
  import spgc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RAM_AW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [RAM_AW-1:0] ramIdx,
  input  logic [DATA_W/8-1:0] busBe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              haltAck,
  output logic              stopBit,
  output logic              frzEn,
  output logic              haltReqBit,
  output logic [DATA_W-1:0] busRdata
);
  localparam int LANES     = DATA_W / 8;
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] levelQ;
  logic [DATA_W-1:0] ramQ [RAM_DEPTH];
  logic [DATA_W-1:0] rdMux;

  function automatic logic [DATA_W-1:0] laneMerge(
    input logic [DATA_W-1:0] oldV, input logic [DATA_W-1:0] newV,
    input logic [LANES-1:0] be);
    logic [DATA_W-1:0] r;
    r = oldV;
    for (int l = 0; l < LANES; l++)
      if (be[l]) r[l*8 +: 8] = newV[l*8 +: 8];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopBit    <= 1'b0;
      frzEn      <= 1'b0;
      haltReqBit <= 1'b0;
      levelQ     <= '0;
    end else begin
      if (strb.wrCfg && busBe[CFG_STOP_BIT/8]) stopBit <= busWdata[CFG_STOP_BIT];
      if (strb.wrCfg && busBe[CFG_FRZ_BIT/8])  frzEn   <= busWdata[CFG_FRZ_BIT];
      if (strb.wrSpiCtl && busBe[SPI_HALT_BIT/8]) haltReqBit <= busWdata[SPI_HALT_BIT];
      if (strb.wrLvl) levelQ <= laneMerge(levelQ, busWdata, busBe);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_DEPTH; i++) ramQ[i] <= '0;
    end else if (strb.wrRam) begin
      ramQ[ramIdx] <= laneMerge(ramQ[ramIdx], busWdata, busBe);
    end
  end

  always_comb begin
    rdMux = '0;
    case (strb.rdSel)
      SEL_CFG: begin
        rdMux[CFG_STOP_BIT] = stopBit;
        rdMux[CFG_FRZ_BIT]  = frzEn;
      end
      SEL_LVL:     rdMux = levelQ;
      SEL_SPICTL:  rdMux[SPI_HALT_BIT] = haltReqBit;
      SEL_SPISTAT: rdMux[0] = haltAck;
      SEL_RAM:     rdMux = ramQ[ramIdx];
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= strb.rdLoad ? rdMux : '0;
  end
endmodule

// File: rtl/serial_periph_global_ctl.sv
module serial_periph_global_ctl
  import spgc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W/8-1:0] busBe,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic                busSuper,
  input  logic                freezeIn,
  input  logic                spiBoundary,
  input  logic                uartBoundary,
  output logic [DATA_W-1:0]   busRdata,
  output logic                respValid,
  output logic                busErr,
  output logic                rdInvalid,
  output logic                periphClkEn,
  output logic                spiHalt,
  output logic                uartTxHalt
);
  localparam int RAM_AW = ADDR_W - 1;

  strobes_t strb;
  logic stopBit, frzEn, haltReqBit;

  spgc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk, .rstN, .busValid, .busWrite, .busAddr, .busSuper,
    .stopBit, .frzEn, .haltReqBit, .freezeIn, .spiBoundary, .uartBoundary,
    .strb, .respValid, .busErr, .rdInvalid, .spiHalt, .uartTxHalt
  );

  spgc_regs #(.DATA_W(DATA_W), .RAM_AW(RAM_AW)) u_regs (
    .clk, .rstN, .strb, .ramIdx(busAddr[RAM_AW-1:0]), .busBe, .busWdata,
    .haltAck(spiHalt), .stopBit, .frzEn, .haltReqBit, .busRdata
  );

  assign periphClkEn = !stopBit;

  assert_err_reads_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> busRdata == '0);
  assert_invalid_reads_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdInvalid |-> (busRdata == '0 && respValid));
endmodule

// File: tb/serial_periph_global_ctl_test.sv
module serial_periph_global_ctl_test;
  logic clk = 0, rstN = 0;
  logic busValid = 0, busWrite = 0, busSuper = 0;
  logic [5:0] busAddr = 0;
  logic [1:0] busBe = 0;
  logic [15:0] busWdata = 0;
  logic freezeIn = 0, spiBoundary = 0, uartBoundary = 0;
  logic [15:0] busRdata;
  logic respValid, busErr, rdInvalid, periphClkEn, spiHalt, uartTxHalt;
  int checks = 0, errors = 0;

  localparam logic [5:0] A_CFG = 0, A_LVL = 1, A_CTL = 2, A_STAT = 3, A_RAM = 32;

  serial_periph_global_ctl uut (.*);

  always #4 clk = ~clk;

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic [1:0] be,
                    input logic sup, output logic err);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d; busBe = be; busSuper = sup;
    @(negedge clk);
    busValid = 0; busWrite = 0;
    err = busErr;
  endtask

  task automatic rd(input logic [5:0] a, input logic sup,
                    output logic [15:0] d, output logic inv, output logic err);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a; busSuper = sup;
    @(negedge clk);
    busValid = 0;
    d = busRdata; inv = rdInvalid; err = busErr;
  endtask

  task automatic pulseSpi();
    @(negedge clk); spiBoundary = 1;
    @(negedge clk); spiBoundary = 0;
  endtask

  task automatic pulseUart();
    @(negedge clk); uartBoundary = 1;
    @(negedge clk); uartBoundary = 0;
  endtask

  task automatic testReset();
    logic [15:0] d; logic inv, err;
    chk("R1 clkEn", periphClkEn, 1);
    chk("R1 spiHalt", spiHalt, 0);
    chk("R1 uartTxHalt", uartTxHalt, 0);
    rd(A_CFG, 1, d, inv, err);  chk("R1 cfg", d, 0);
    rd(A_LVL, 1, d, inv, err);  chk("R1 lvl", d, 0);
    rd(A_RAM + 7, 1, d, inv, err); chk("R1 ram", d, 0);
  endtask

  task automatic testStopRw();
    logic [15:0] d; logic inv, err;
    wr(A_CFG, 16'h8000, 2'b11, 1, err);
    chk("R2 clkEn off", periphClkEn, 0);
    rd(A_CFG, 1, d, inv, err);
    chk("R3 cfg data", d, 16'h8000); chk("R3 cfg valid", inv, 0);
    wr(A_LVL, 16'h1234, 2'b11, 1, err);
    wr(A_RAM + 5, 16'hBEEF, 2'b11, 1, err);
    rd(A_RAM + 5, 1, d, inv, err);
    chk("R3 ram zero", d, 0); chk("R3 ram invalid", inv, 1);
    rd(A_LVL, 1, d, inv, err);
    chk("R3 lvl zero", d, 0); chk("R3 lvl invalid", inv, 1);
    wr(A_CFG, 16'h0000, 2'b11, 1, err);
    chk("R2 clkEn on", periphClkEn, 1);
    rd(A_RAM + 5, 1, d, inv, err);
    chk("R4 ram kept", d, 16'hBEEF); chk("R4 valid", inv, 0);
    rd(A_LVL, 1, d, inv, err); chk("R4 lvl kept", d, 16'h1234);
  endtask

  task automatic testLanes();
    logic [15:0] d; logic inv, err;
    wr(A_RAM + 1, 16'hFFFF, 2'b11, 1, err);
    wr(A_RAM + 1, 16'h1234, 2'b01, 1, err);
    rd(A_RAM + 1, 1, d, inv, err); chk("R5 low lane", d, 16'hFF34);
    wr(A_RAM + 1, 16'hAB00, 2'b10, 1, err);
    rd(A_RAM + 1, 1, d, inv, err); chk("R5 high lane", d, 16'hAB34);
    wr(A_CFG, 16'h8000, 2'b01, 1, err);
    chk("R5 stop lane off", periphClkEn, 1);
  endtask

  task automatic testPrivilege();
    logic [15:0] d; logic inv, err;
    wr(A_CFG, 16'h8000, 2'b11, 0, err);
    chk("R6 write err", err, 1);
    @(negedge clk); chk("R6 err one cycle", busErr, 0);
    chk("R6 write discarded", periphClkEn, 1);
    rd(A_LVL, 0, d, inv, err);
    chk("R6 read err", err, 1); chk("R6 read zero", d, 0);
    wr(A_RAM + 9, 16'h5A5A, 2'b11, 0, err); chk("R7 ram write ok", err, 0);
    rd(A_RAM + 9, 0, d, inv, err);
    chk("R7 ram read", d, 16'h5A5A); chk("R7 no err", err, 0);
    wr(A_CTL, 16'h0001, 2'b11, 0, err); chk("R7 ctl ok", err, 0);
    rd(A_CTL, 0, d, inv, err); chk("R7 ctl read", d, 1);
    wr(A_CTL, 16'h0000, 2'b11, 0, err);
    repeat (2) @(negedge clk);
  endtask

  task automatic testFreezeEnabled();
    logic err;
    wr(A_CFG, 16'h4000, 2'b11, 1, err);
    @(negedge clk); freezeIn = 1;
    repeat (3) @(negedge clk);
    chk("R8 waits boundary", spiHalt, 0);
    pulseSpi();
    chk("R8 halted", spiHalt, 1);
    freezeIn = 0;
    @(negedge clk);
    chk("R8 release", spiHalt, 0);
  endtask

  task automatic testFreezeDisabled();
    logic err;
    wr(A_CFG, 16'h0000, 2'b11, 1, err);
    @(negedge clk); freezeIn = 1;
    pulseSpi();
    chk("R9 spi not halted", spiHalt, 0);
    chk("R9 uart waits", uartTxHalt, 0);
    pulseUart();
    chk("R9 uart halted", uartTxHalt, 1);
    freezeIn = 0;
    @(negedge clk);
    chk("R9 uart release", uartTxHalt, 0);
  endtask

  task automatic testSoftHalt();
    logic [15:0] d; logic inv, err;
    wr(A_CTL, 16'h0001, 2'b11, 1, err);
    rd(A_STAT, 1, d, inv, err); chk("R10 ack before", d, 0);
    pulseSpi();
    chk("R10 spiHalt", spiHalt, 1);
    rd(A_STAT, 1, d, inv, err); chk("R10 ack set", d, 1);
    wr(A_CTL, 16'h0000, 2'b11, 1, err);
    @(negedge clk);
    chk("R10 spiHalt clear", spiHalt, 0);
    rd(A_STAT, 1, d, inv, err); chk("R10 ack clear", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testStopRw();
    testLanes();
    testPrivilege();
    testFreezeEnabled();
    testFreezeDisabled();
    testSoftHalt();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule